// File: doc/BRIEF.md
# Dual-Channel Serial-Readout Pulse Generator

This block produces the per-pixel drive and sampling strobes for an image sensor that reads each line out through two serial shift registers. One register carries the odd columns and the other the even columns. Every output is a registered level on a master-clock grid. Channel A's serial clock is high in the first half of each pixel period. Channel B runs the same pattern half a period later. Each channel has its own reset gate, pre-sample clamp, sample-and-hold strobe and dark-reference clamp window, so an external correlated double sampler can be served on each channel. Composite blanking and a sync pulse frame the line.

The block waits in idle until a vertical sequencer signals that a line has been loaded. It then runs a transfer interval in which both serial clocks are held high together, matching the transfer-gate pulse. After that it runs a readout of `NPULSE` pixel periods of `PIX` master cycles each and returns to idle. The pixel period, pulse count, transfer length and every strobe offset are parameters given in master-clock cycles. The defaults are a 14-cycle pixel (under 10 MHz per register from a 125 MHz master clock), 541 pulses, a 16-cycle transfer, 12 dummy and 12 black-reference elements per register, and sampling 3 cycles (24 ns) after the serial clock falls.

Top module: `hpg_top`

## Requirements
- R1: While in reset and while idle, all serial clocks, reset gates, clamps, samples, dark clamps and sync are low, and blank is high.
- R2: A `line_start` high at a clock edge in idle begins a transfer interval of `XFER_LEN` cycles. Both serial clocks are high for its first `XFER_LEN-1` cycles and low in its last cycle, and reset, clamp, sample and dark outputs stay low throughout it.
- R3: Readout follows the transfer interval and lasts `NPULSE` pixel periods of `PIX` cycles. Channel A's serial clock is high during phases 0 to `PIX/2-1` of each period, so that across one whole line each serial clock rises `NPULSE+1` times, counting the transfer pulse.
- R4: Channel B's serial clock and strobes are channel A's pattern delayed by `PIX/2` cycles, and the two serial clocks are never high together during readout.
- R5: In every pixel of a channel, its reset gate is high for `RST_LEN` cycles starting at local phase `RST_AT`. Local phase 0 is that channel's serial-clock rising edge.
- R6: Each channel's clamp is high for `CL_LEN` cycles from local phase `CL_AT`. Its sample strobe is high for `SH_LEN` cycles from local phase `SH_AT`, which is at least 3 cycles after the serial clock falls. Reset, clamp and sample follow each other in that order without overlap.
- R7: Each channel's dark-reference clamp is high for the whole of that channel's pixels with 0-based index `DUMMY` to `DUMMY+BLACK-1`, and low otherwise.
- R8: Blank is high except during readout from phase `PIX/2` of pixel `DUMMY+BLACK` onward. Sync is high exactly in transfer cycles `SYNC_AT` to `SYNC_AT+SYNC_LEN-1`.
- R9: A `line_start` that arrives while a line is in progress is ignored: the current line continues unchanged and no second line follows.
- R10: After the last pixel the block returns to idle. A `line_start` in the first idle cycle starts the next line at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | A line has been loaded into the serial registers |
| srg_a | output | 1 | Serial-register clock, channel A |
| srg_b | output | 1 | Serial-register clock, channel B |
| rg_a | output | 1 | Reset gate, channel A |
| rg_b | output | 1 | Reset gate, channel B |
| clamp_a | output | 1 | Pixel clamp strobe, channel A |
| clamp_b | output | 1 | Pixel clamp strobe, channel B |
| samp_a | output | 1 | Sample-and-hold strobe, channel A |
| samp_b | output | 1 | Sample-and-hold strobe, channel B |
| dark_a | output | 1 | Dark-reference clamp window, channel A |
| dark_b | output | 1 | Dark-reference clamp window, channel B |
| blank | output | 1 | Composite blanking |
| sync | output | 1 | Composite sync |

## Verification
A wrong phase or pixel count shows up within one pixel period as a strobe in the wrong cycle on one channel. It also shows up at the line level as a wrong number of serial-clock edges and a blanking edge in the wrong cycle. A wrong mode is caught at once: a missed return to idle leaves the serial clocks toggling after the line should have ended, and a restart accepted mid-line pulls both serial clocks high together during readout. Every output is compared cycle by cycle against a model derived from the requirements, for whole lines including restarts during both transfer and readout.

// File: rtl/hpg_pkg.sv
package hpg_pkg;

    typedef enum logic [1:0] {
        H_IDLE = 2'd0,
        H_XFER = 2'd1,
        H_READ = 2'd2
    } hmode_e;

    function automatic logic in_win(input int v, input int at, input int len);
        return (v >= at) && (v < at + len);
    endfunction

endpackage

// File: rtl/hpg_seq.sv
module hpg_seq
    import hpg_pkg::*;
#(
    parameter int PIX      = 14,
    parameter int NPULSE   = 541,
    parameter int XFER_LEN = 16,
    localparam int PHW = (PIX > 1) ? $clog2(PIX) : 1,
    localparam int PXW = (NPULSE > 1) ? $clog2(NPULSE) : 1,
    localparam int XW  = (XFER_LEN > 1) ? $clog2(XFER_LEN) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           line_start,
    output hmode_e         mode_q,
    output hmode_e         mode_d,
    output logic [XW-1:0]  xc_d,
    output logic [PHW-1:0] ph_d,
    output logic [PXW-1:0] px_d
);

    typedef struct packed {
        hmode_e         mode;
        logic [XW-1:0]  xc;
        logic [PHW-1:0] ph;
        logic [PXW-1:0] px;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.mode)
            H_IDLE: begin
                if (line_start) begin
                    st_d.mode = H_XFER;
                    st_d.xc   = '0;
                end
            end
            H_XFER: begin
                if (int'(st_q.xc) == XFER_LEN - 1) begin
                    st_d.mode = H_READ;
                    st_d.ph   = '0;
                    st_d.px   = '0;
                end else begin
                    st_d.xc = st_q.xc + 1'b1;
                end
            end
            H_READ: begin
                if (int'(st_q.ph) == PIX - 1) begin
                    st_d.ph = '0;
                    if (int'(st_q.px) == NPULSE - 1) begin
                        st_d.mode = H_IDLE;
                    end else begin
                        st_d.px = st_q.px + 1'b1;
                    end
                end else begin
                    st_d.ph = st_q.ph + 1'b1;
                end
            end
            default: st_d.mode = H_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_q = st_q.mode;
    assign mode_d = st_d.mode;
    assign xc_d   = st_d.xc;
    assign ph_d   = st_d.ph;
    assign px_d   = st_d.px;

endmodule

// File: rtl/hpg_chan.sv
module hpg_chan
    import hpg_pkg::*;
#(
    parameter int PIX      = 14,
    parameter int NPULSE   = 541,
    parameter int XFER_LEN = 16,
    parameter int OFF      = 0,
    parameter int RST_AT   = 0,
    parameter int RST_LEN  = 2,
    parameter int CL_AT    = 3,
    parameter int CL_LEN   = 2,
    parameter int SH_AT    = 10,
    parameter int SH_LEN   = 2,
    parameter int DUMMY    = 12,
    parameter int BLACK    = 12,
    localparam int HALF = PIX / 2,
    localparam int PHW  = (PIX > 1) ? $clog2(PIX) : 1,
    localparam int PXW  = (NPULSE > 1) ? $clog2(NPULSE) : 1,
    localparam int XW   = (XFER_LEN > 1) ? $clog2(XFER_LEN) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  hmode_e         mode_i,
    input  logic [XW-1:0]  xc_i,
    input  logic [PHW-1:0] ph_i,
    input  logic [PXW-1:0] px_i,
    output logic           srg_o,
    output logic           rg_o,
    output logic           cl_o,
    output logic           sh_o,
    output logic           dk_o
);

    typedef struct packed {
        logic srg;
        logic rg;
        logic cl;
        logic sh;
        logic dk;
    } chan_out_t;

    chan_out_t o_d, o_q;
    int        lph_c;
    int        idx_c;
    logic      run_c;

    always_comb begin
        // local phase and pixel index as seen from this channel's own grid
        if (int'(ph_i) >= OFF) begin
            lph_c = int'(ph_i) - OFF;
            idx_c = int'(px_i);
        end else begin
            lph_c = int'(ph_i) + PIX - OFF;
            idx_c = int'(px_i) - 1;
        end
        run_c = (mode_i == H_READ) && (idx_c >= 0);

        o_d.srg = ((mode_i == H_XFER) && (int'(xc_i) < XFER_LEN - 1))
                || (run_c && (lph_c < HALF));
        o_d.rg  = run_c && in_win(lph_c, RST_AT, RST_LEN);
        o_d.cl  = run_c && in_win(lph_c, CL_AT, CL_LEN);
        o_d.sh  = run_c && in_win(lph_c, SH_AT, SH_LEN);
        o_d.dk  = run_c && in_win(idx_c, DUMMY, BLACK);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign srg_o = o_q.srg;
    assign rg_o  = o_q.rg;
    assign cl_o  = o_q.cl;
    assign sh_o  = o_q.sh;
    assign dk_o  = o_q.dk;

endmodule

// File: rtl/hpg_comp.sv
module hpg_comp
    import hpg_pkg::*;
#(
    parameter int PIX      = 14,
    parameter int NPULSE   = 541,
    parameter int XFER_LEN = 16,
    parameter int FIRST    = 24,
    parameter int SYNC_AT  = 2,
    parameter int SYNC_LEN = 8,
    localparam int HALF = PIX / 2,
    localparam int PHW  = (PIX > 1) ? $clog2(PIX) : 1,
    localparam int PXW  = (NPULSE > 1) ? $clog2(NPULSE) : 1,
    localparam int XW   = (XFER_LEN > 1) ? $clog2(XFER_LEN) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  hmode_e         mode_i,
    input  logic [XW-1:0]  xc_i,
    input  logic [PHW-1:0] ph_i,
    input  logic [PXW-1:0] px_i,
    output logic           blank_o,
    output logic           sync_o
);

    typedef struct packed {
        logic blank;
        logic sync;
    } comp_out_t;

    comp_out_t c_d, c_q;
    logic      img_c;

    always_comb begin
        // image starts once the later channel reaches its first image element
        img_c = (int'(px_i) > FIRST)
             || ((int'(px_i) == FIRST) && (int'(ph_i) >= HALF));
        c_d.blank = !((mode_i == H_READ) && img_c);
        c_d.sync  = (mode_i == H_XFER) && in_win(int'(xc_i), SYNC_AT, SYNC_LEN);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '{blank: 1'b1, sync: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign blank_o = c_q.blank;
    assign sync_o  = c_q.sync;

endmodule

// File: rtl/hpg_top.sv
module hpg_top
    import hpg_pkg::*;
#(
    parameter int PIX      = 14,
    parameter int NPULSE   = 541,
    parameter int XFER_LEN = 16,
    parameter int RST_AT   = 0,
    parameter int RST_LEN  = 2,
    parameter int CL_AT    = 3,
    parameter int CL_LEN   = 2,
    parameter int SH_AT    = 10,
    parameter int SH_LEN   = 2,
    parameter int DUMMY    = 12,
    parameter int BLACK    = 12,
    parameter int SYNC_AT  = 2,
    parameter int SYNC_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_start,
    output logic srg_a,
    output logic srg_b,
    output logic rg_a,
    output logic rg_b,
    output logic clamp_a,
    output logic clamp_b,
    output logic samp_a,
    output logic samp_b,
    output logic dark_a,
    output logic dark_b,
    output logic blank,
    output logic sync
);

    localparam int HALF  = PIX / 2;
    localparam int FIRST = DUMMY + BLACK;
    localparam int PHW   = (PIX > 1) ? $clog2(PIX) : 1;
    localparam int PXW   = (NPULSE > 1) ? $clog2(NPULSE) : 1;
    localparam int XW    = (XFER_LEN > 1) ? $clog2(XFER_LEN) : 1;

    hmode_e         seq_mode_q;
    hmode_e         seq_mode_d;
    logic [XW-1:0]  seq_xc_d;
    logic [PHW-1:0] seq_ph_d;
    logic [PXW-1:0] seq_px_d;

    logic [1:0] srg_w, rg_w, cl_w, sh_w, dk_w;

    hpg_seq #(
        .PIX(PIX), .NPULSE(NPULSE), .XFER_LEN(XFER_LEN)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .line_start(line_start),
        .mode_q(seq_mode_q), .mode_d(seq_mode_d),
        .xc_d(seq_xc_d), .ph_d(seq_ph_d), .px_d(seq_px_d)
    );

    for (genvar c = 0; c < 2; c++) begin : g_chan
        hpg_chan #(
            .PIX(PIX), .NPULSE(NPULSE), .XFER_LEN(XFER_LEN),
            .OFF(c * HALF),
            .RST_AT(RST_AT), .RST_LEN(RST_LEN),
            .CL_AT(CL_AT), .CL_LEN(CL_LEN),
            .SH_AT(SH_AT), .SH_LEN(SH_LEN),
            .DUMMY(DUMMY), .BLACK(BLACK)
        ) u_chan (
            .clk(clk), .rst_n(rst_n),
            .mode_i(seq_mode_d), .xc_i(seq_xc_d),
            .ph_i(seq_ph_d), .px_i(seq_px_d),
            .srg_o(srg_w[c]), .rg_o(rg_w[c]), .cl_o(cl_w[c]),
            .sh_o(sh_w[c]), .dk_o(dk_w[c])
        );
    end

    hpg_comp #(
        .PIX(PIX), .NPULSE(NPULSE), .XFER_LEN(XFER_LEN),
        .FIRST(FIRST), .SYNC_AT(SYNC_AT), .SYNC_LEN(SYNC_LEN)
    ) u_comp (
        .clk(clk), .rst_n(rst_n),
        .mode_i(seq_mode_d), .xc_i(seq_xc_d),
        .ph_i(seq_ph_d), .px_i(seq_px_d),
        .blank_o(blank), .sync_o(sync)
    );

    assign srg_a   = srg_w[0];
    assign srg_b   = srg_w[1];
    assign rg_a    = rg_w[0];
    assign rg_b    = rg_w[1];
    assign clamp_a = cl_w[0];
    assign clamp_b = cl_w[1];
    assign samp_a  = sh_w[0];
    assign samp_b  = sh_w[1];
    assign dark_a  = dk_w[0];
    assign dark_b  = dk_w[1];

endmodule

// File: rtl/hpg_chk.sv
module hpg_chk
    import hpg_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input hmode_e mode,
    input logic   srg_a,
    input logic   srg_b,
    input logic   rg_a,
    input logic   rg_b,
    input logic   clamp_a,
    input logic   clamp_b,
    input logic   samp_a,
    input logic   samp_b,
    input logic   dark_a,
    input logic   dark_b,
    input logic   blank,
    input logic   sync
);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == H_IDLE) |-> (!srg_a && !srg_b && !rg_a && !rg_b && !clamp_a
            && !clamp_b && !samp_a && !samp_b && !dark_a && !dark_b && !sync && blank));

    assert_xfer_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == H_XFER && $past(mode) == H_IDLE) |-> (srg_a && srg_b));

    assert_clocks_apart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == H_READ) |-> !(srg_a && srg_b));

    assert_rst_vs_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !((rg_a && samp_a) || (rg_b && samp_b) || (clamp_a && samp_a) || (clamp_b && samp_b)));

    assert_dark_in_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dark_a || dark_b) |-> blank);

    assert_sync_in_xfer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sync |-> (blank && mode == H_XFER));

    assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == H_READ) |-> (mode != H_XFER));

endmodule

bind hpg_top hpg_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mode(seq_mode_q),
    .srg_a(srg_a), .srg_b(srg_b), .rg_a(rg_a), .rg_b(rg_b),
    .clamp_a(clamp_a), .clamp_b(clamp_b), .samp_a(samp_a), .samp_b(samp_b),
    .dark_a(dark_a), .dark_b(dark_b), .blank(blank), .sync(sync)
);

// File: tb/sim_hpg_top.sv
`timescale 1ns/1ps
module sim_hpg_top;

    localparam int PIX = 14, NP = 541, XL = 16, HALF = PIX / 2;
    localparam int RA = 0, RL = 2, CA = 3, CLN = 2, SA = 10, SL = 2;
    localparam int DUM = 12, BLK = 12, YA = 2, YL = 8;
    localparam int LL = XL + NP * PIX;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_start = 1'b0;
    logic srg_a, srg_b, rg_a, rg_b, clamp_a, clamp_b, samp_a, samp_b;
    logic dark_a, dark_b, blank, sync;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hpg_top #(
        .PIX(PIX), .NPULSE(NP), .XFER_LEN(XL), .RST_AT(RA), .RST_LEN(RL),
        .CL_AT(CA), .CL_LEN(CLN), .SH_AT(SA), .SH_LEN(SL), .DUMMY(DUM),
        .BLACK(BLK), .SYNC_AT(YA), .SYNC_LEN(YL)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .line_start(line_start),
        .srg_a(srg_a), .srg_b(srg_b), .rg_a(rg_a), .rg_b(rg_b),
        .clamp_a(clamp_a), .clamp_b(clamp_b), .samp_a(samp_a), .samp_b(samp_b),
        .dark_a(dark_a), .dark_b(dark_b), .blank(blank), .sync(sync)
    );

    function automatic logic [11:0] actual();
        return {srg_a, srg_b, rg_a, rg_b, clamp_a, clamp_b,
                samp_a, samp_b, dark_a, dark_b, blank, sync};
    endfunction

    // expected outputs t cycles after the accepted line_start edge
    function automatic logic [11:0] expv(int t);
        logic [11:0] e;
        e = 12'b0;
        e[1] = 1'b1;
        if (t >= 0 && t < XL) begin
            e[11] = (t < XL - 1);
            e[10] = (t < XL - 1);
            e[0]  = (t >= YA) && (t < YA + YL);
        end else if (t >= XL && t < LL) begin
            int r, p, ph;
            r = t - XL; p = r / PIX; ph = r % PIX;
            for (int c = 0; c < 2; c++) begin
                int off, lp, ix;
                off = c * HALF;
                lp = (ph >= off) ? ph - off : ph + PIX - off;
                ix = (ph >= off) ? p : p - 1;
                if (ix >= 0) begin
                    e[11 - c] = (lp < HALF);
                    e[9 - c]  = (lp >= RA) && (lp < RA + RL);
                    e[7 - c]  = (lp >= CA) && (lp < CA + CLN);
                    e[5 - c]  = (lp >= SA) && (lp < SA + SL);
                    e[3 - c]  = (ix >= DUM) && (ix < DUM + BLK);
                end
            end
            e[1] = !((p > DUM + BLK) || (p == DUM + BLK && ph >= HALF));
        end
        return e;
    endfunction

    function automatic string tag_of(int b, int t);
        if (t < 0 || t >= LL) return "R10";
        if (t < XL) return (b == 0 || b == 1) ? "R8" : "R2";
        case (b)
            11: return "R3";
            10: return "R4";
            9, 8: return "R5";
            7, 6, 5, 4: return "R6";
            3, 2: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic cmp_vec(int t, string force_tag);
        logic [11:0] a, e;
        a = actual();
        e = expv(t);
        for (int b = 0; b < 12; b++) begin
            n_vec++;
            if (a[b] !== e[b]) begin
                n_bad++;
                $display("FAIL %s t=%0d bit%0d actual=%b expected=%b",
                         (force_tag != "") ? force_tag : tag_of(b, t), t, b, a[b], e[b]);
            end
        end
    endtask

    task automatic chk(string tag, int act, int exp_v);
        n_vec++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    // one line; ig1/ig2 are cycles at which a stray line_start is raised
    task automatic run_line(int ig1, int ig2, int tail, bit pre_armed,
                            bit arm_next, string ftag);
        int rises_a, rises_b;
        logic pa, pb;
        rises_a = 0; rises_b = 0; pa = 1'b0; pb = 1'b0;
        if (!pre_armed) begin
            @(negedge clk);
            line_start = 1'b1;
        end
        for (int t = 0; t < LL + tail; t++) begin
            @(negedge clk);
            line_start = 1'b0;
            cmp_vec(t, (t >= LL) ? ftag : "");
            if (t < LL) begin
                if (srg_a && !pa) rises_a++;
                if (srg_b && !pb) rises_b++;
                pa = srg_a; pb = srg_b;
            end
            if (t == ig1 || t == ig2) line_start = 1'b1;
            if (arm_next && t == LL + tail - 1) line_start = 1'b1;
        end
        chk("R3 srg_a rises per line", rises_a, NP + 1);
        chk("R3 srg_b rises per line", rises_b, NP + 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        line_start = 1'b1;
        repeat (3) @(negedge clk);
        cmp_vec(-1, "R1");
        line_start = 1'b0;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        cmp_vec(-1, "R1");
    endtask

    task automatic t_plain_line();
        run_line(-5, -5, 6, 1'b0, 1'b0, "R10");
    endtask

    task automatic t_ignore_busy();
        // stray starts in transfer, mid readout and on the last readout cycle
        run_line(5, 3000, 20, 1'b0, 1'b0, "R9");
        run_line(LL - 2, -5, 20, 1'b0, 1'b0, "R9");
    endtask

    task automatic t_back_to_back();
        run_line(-5, -5, 1, 1'b0, 1'b1, "R10");
        run_line(-5, -5, 4, 1'b1, 1'b0, "R10");
    endtask

    initial begin
        t_reset();
        t_plain_line();
        t_ignore_busy();
        t_back_to_back();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule